// File: doc/BRIEF.md
# ULPI PHY Register Access Engine

This block sits on the PHY side of a ULPI link. It watches the link-driven data byte for register commands, runs the NXT/DIR/STP exchange for them, and serves each command from a small local register file. Five control registers are held here. Each one can be written at three neighbouring addresses: the first replaces the value, the second ORs bits in, and the third clears the bits that are set in the data byte. The rest of the PHY sees all control registers as parallel output buses, and it feeds in the live values of the interrupt status and debug registers.

Commands use immediate 6-bit addresses. A link that needs the full 8-bit address space sends the escape address, and a second byte then carries the whole address. The PHY raises `phy_take` when it needs the bus. That signal cancels any operation in progress without side effects. Read data goes out on a dedicated output that stays at zero unless the engine owns the bus. The chip-level pad multiplexer combines it with the PHY's other bus traffic.

Top module: `ulpi_reg_engine`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `ulpi_nxt` and `ulpi_dir` are 0 and `ulpi_dout` is 00h. The control registers take their reset parameters; the defaults are 41h for function control and 00h for the others.
- R2: A byte with bits [7:6] = 10b is a write command to the address in bits [5:0]. For every byte it accepts, the engine holds NXT low for one cycle and then high for one cycle (the command, then the data). After the data byte it waits for STP. The update is committed on the STP cycle and shows on the register outputs on the following cycle.
- R3: Function control is at 04h, interface control at 07h, OTG control at 0Ah, rising-edge interrupt enable at 0Dh and power control at 3Dh. For each of them, base+0 replaces the value, base+1 ORs in the data, and base+2 ANDs with the inverted data. A read at any of the three addresses returns the stored value.
- R4: A byte with bits [7:6] = 11b is a read command. After the NXT cycle, DIR is high for two cycles. `ulpi_dout` is 00h in the first (turnaround) cycle and carries the register value in the second. DIR then drops for a turnaround cycle with `ulpi_dout` at 00h.
- R5: A command address of 2Fh selects extended addressing. The next byte gets its own NXT-low/NXT-high pair and supplies the full 8-bit address. Extended addresses 00h–3Fh reach the same registers as immediate ones, and addresses above 3Fh are reserved.
- R6: Addresses 00h/01h read the vendor ID low/high byte and 02h/03h read the product ID low/high byte, all from parameters. Writes to them have no effect.
- R7: Address 13h reads the live interrupt status input and 15h the live debug input. Writes to either change no register.
- R8: Reserved addresses read as 00h, and writes to them change no register.
- R9: When `phy_take` is high in a cycle, the engine is idle on the next cycle (NXT and DIR low). A pending write is dropped even if STP arrives in that same cycle, and a command byte offered in that cycle is ignored.
- R10: After the data byte of a write, the engine waits with NXT low for any number of cycles until STP arrives.
- R11: Bytes whose bits [7:6] are 00b or 01b start no register operation: NXT stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ulpi_din | input | 8 | Data byte driven by the link |
| ulpi_stp | input | 1 | Link stop strobe |
| phy_take | input | 1 | PHY needs the bus; cancels the current operation |
| stat_intr | input | 8 | Live interrupt status value, read at 13h |
| stat_debug | input | 8 | Live debug value, read at 15h |
| ulpi_dout | output | 8 | Read data toward the link; 00h when not driving |
| ulpi_dir | output | 1 | Engine owns the data bus (read turnaround and data) |
| ulpi_nxt | output | 1 | Engine accepts the current byte |
| reg_func | output | 8 | Function control register |
| reg_intf | output | 8 | Interface control register |
| reg_otg | output | 8 | OTG control register |
| reg_intr_rise | output | 8 | Rising-edge interrupt enable register |
| reg_pwr | output | 8 | Power control register |

## Verification
The assertions cover properties that hold on every cycle. NXT and DIR are never high together. Read data is zero unless DIR is high. NXT never lasts longer than a single cycle, and DIR never lasts longer than two. The register outputs change only on a cycle that follows STP. `phy_take` always leaves the engine idle on the next cycle. Other properties need a reference value, and only the bench scenarios can show them: that set and clear produce the right bit results at all five register triplets, that the extended form reaches the same storage as the immediate form, that ID, status and reserved reads return the right bytes, and that a write cancelled by `phy_take` together with STP leaves the stored value untouched.

// File: rtl/ulpi_reg_pkg.sv
// Shared constants, types and helpers for the ULPI register access engine.
// Assumes 8-bit data and 8-bit register addresses; immediate commands carry
// 6 address bits.
package ulpi_reg_pkg;

    localparam int DW     = 8;
    localparam int AW     = 8;
    localparam int IMM_AW = 6;
    localparam int NCTRL  = 5;

    localparam logic [IMM_AW-1:0] EXT_ESC = 6'h2F;

    localparam logic [AW-1:0] ADDR_VID_LO = 8'h00;
    localparam logic [AW-1:0] ADDR_VID_HI = 8'h01;
    localparam logic [AW-1:0] ADDR_PID_LO = 8'h02;
    localparam logic [AW-1:0] ADDR_PID_HI = 8'h03;
    localparam logic [AW-1:0] ADDR_STAT   = 8'h13;
    localparam logic [AW-1:0] ADDR_DBG    = 8'h15;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD_ACK,
        S_EXT_WAIT,
        S_EXT_ACK,
        S_DAT_WAIT,
        S_DAT_ACK,
        S_WAIT_STP,
        S_RD_TA1,
        S_RD_DATA,
        S_RD_TA2
    } eng_state_e;

    // Base (plain-write) address of control register idx; +1 sets, +2 clears.
    function automatic logic [AW-1:0] ctrl_base(input int idx);
        case (idx)
            0:       return 8'h04;
            1:       return 8'h07;
            2:       return 8'h0A;
            3:       return 8'h0D;
            default: return 8'h3D;
        endcase
    endfunction

endpackage

// File: rtl/ulpi_cmd_fsm.sv
// Protocol sequencer for ULPI register commands on the PHY side.
// Decodes the command byte, takes an optional extended address byte and
// the write data byte (each acknowledged with one NXT cycle after one wait
// cycle), waits for STP to commit a write, and times the read turnaround.
// Assumes the link holds each byte until it sees NXT. phy_take cancels any
// operation and blocks new commands.
module ulpi_cmd_fsm
    import ulpi_reg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          stp,
    input  logic          take,
    output logic          nxt,
    output logic          dir,
    output logic          rd_drive,
    output logic          commit,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);

    eng_state_e    state_q;
    eng_state_e    state_d;
    logic          is_rd_q;
    logic          is_ext_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          cmd_seen;

    assign cmd_seen = din[DW-1] && !take;

    // Next-state selection for the command sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (cmd_seen) state_d = S_CMD_ACK;
            S_CMD_ACK:  state_d = is_ext_q ? S_EXT_WAIT
                                           : (is_rd_q ? S_RD_TA1 : S_DAT_WAIT);
            S_EXT_WAIT: state_d = S_EXT_ACK;
            S_EXT_ACK:  state_d = is_rd_q ? S_RD_TA1 : S_DAT_WAIT;
            S_DAT_WAIT: state_d = S_DAT_ACK;
            S_DAT_ACK:  state_d = S_WAIT_STP;
            S_WAIT_STP: if (stp) state_d = S_IDLE;
            S_RD_TA1:   state_d = S_RD_DATA;
            S_RD_DATA:  state_d = S_RD_TA2;
            S_RD_TA2:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
        if (take) state_d = S_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Captures the command kind, the address and the write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_rd_q  <= 1'b0;
            is_ext_q <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else begin
            if (state_q == S_IDLE && cmd_seen) begin
                is_rd_q  <= din[DW-2];
                is_ext_q <= (din[IMM_AW-1:0] == EXT_ESC);
                addr_q   <= {{(AW-IMM_AW){1'b0}}, din[IMM_AW-1:0]};
            end
            if (state_q == S_EXT_ACK) addr_q  <= din;
            if (state_q == S_DAT_ACK) wdata_q <= din;
        end
    end

    // Bus-facing decodes of the current state.
    always_comb begin
        nxt      = (state_q == S_CMD_ACK) || (state_q == S_EXT_ACK) ||
                   (state_q == S_DAT_ACK);
        dir      = (state_q == S_RD_TA1) || (state_q == S_RD_DATA);
        rd_drive = (state_q == S_RD_DATA);
        commit   = (state_q == S_WAIT_STP) && stp && !take;
    end

    assign addr  = addr_q;
    assign wdata = wdata_q;

endmodule

// File: rtl/ulpi_reg_file.sv
// Local register file of the engine: five control registers, each with
// write/set/clear aliases at base, base+1 and base+2; read-only ID bytes
// from parameters; live status and debug inputs. Reserved addresses read
// 00h and ignore writes. Assumes wr_en is a single-cycle commit pulse.
module ulpi_reg_file
    import ulpi_reg_pkg::*;
#(
    parameter logic [15:0]         VENDOR_ID = 16'h1A2B,
    parameter logic [15:0]         PRODUCT_ID = 16'h3C4D,
    parameter logic [NCTRL*DW-1:0] CTRL_RST  = {{(NCTRL-1)*DW{1'b0}}, 8'h41}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    input  logic [DW-1:0]               stat_intr,
    input  logic [DW-1:0]               stat_debug,
    output logic [NCTRL-1:0][DW-1:0]    ctrl_q,
    output logic [DW-1:0]               rd_data
);

    logic [NCTRL-1:0][DW-1:0] ctrl_rd;
    logic [DW-1:0]            fixed_rd;

    for (genvar i = 0; i < NCTRL; i++) begin : g_ctrl
        localparam logic [AW-1:0] BASE = ctrl_base(i);
        logic          hit_wr;
        logic          hit_set;
        logic          hit_clr;
        logic [DW-1:0] q;

        assign hit_wr  = (addr == BASE);
        assign hit_set = (addr == BASE + 8'd1);
        assign hit_clr = (addr == BASE + 8'd2);

        // Storage of one control register with its three write aliases.
        always_ff @(posedge clk) begin
            if (!rst_n)                q <= CTRL_RST[i*DW +: DW];
            else if (wr_en && hit_wr)  q <= wdata;
            else if (wr_en && hit_set) q <= q | wdata;
            else if (wr_en && hit_clr) q <= q & ~wdata;
        end

        assign ctrl_q[i]  = q;
        assign ctrl_rd[i] = (hit_wr || hit_set || hit_clr) ? q : '0;
    end

    // Read value of the fixed, read-only addresses.
    always_comb begin
        case (addr)
            ADDR_VID_LO: fixed_rd = VENDOR_ID[7:0];
            ADDR_VID_HI: fixed_rd = VENDOR_ID[15:8];
            ADDR_PID_LO: fixed_rd = PRODUCT_ID[7:0];
            ADDR_PID_HI: fixed_rd = PRODUCT_ID[15:8];
            ADDR_STAT:   fixed_rd = stat_intr;
            ADDR_DBG:    fixed_rd = stat_debug;
            default:     fixed_rd = '0;
        endcase
    end

    // Merges the control-register hits with the fixed read value.
    always_comb begin
        rd_data = fixed_rd;
        for (int k = 0; k < NCTRL; k++) rd_data = rd_data | ctrl_rd[k];
    end

endmodule

// File: rtl/ulpi_reg_engine.sv
// Top of the ULPI PHY register access engine: the command sequencer
// connected to the register file. Read data is gated to zero whenever the
// engine does not drive the bus, so the chip can OR it with other sources.
module ulpi_reg_engine
    import ulpi_reg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
    parameter logic [15:0] PRODUCT_ID = 16'h3C4D,
    parameter logic [7:0]  FUNC_RST   = 8'h41,
    parameter logic [7:0]  INTF_RST   = 8'h00,
    parameter logic [7:0]  OTG_RST    = 8'h00,
    parameter logic [7:0]  INTR_RST   = 8'h00,
    parameter logic [7:0]  PWR_RST    = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] ulpi_din,
    input  logic       ulpi_stp,
    input  logic       phy_take,
    input  logic [7:0] stat_intr,
    input  logic [7:0] stat_debug,
    output logic [7:0] ulpi_dout,
    output logic       ulpi_dir,
    output logic       ulpi_nxt,
    output logic [7:0] reg_func,
    output logic [7:0] reg_intf,
    output logic [7:0] reg_otg,
    output logic [7:0] reg_intr_rise,
    output logic [7:0] reg_pwr
);

    localparam logic [NCTRL*DW-1:0] CTRL_RST =
        {PWR_RST, INTR_RST, OTG_RST, INTF_RST, FUNC_RST};

    logic                     rd_drive;
    logic                     commit;
    logic [AW-1:0]            addr;
    logic [DW-1:0]            wdata;
    logic [DW-1:0]            rd_data;
    logic [NCTRL-1:0][DW-1:0] ctrl_q;

    ulpi_cmd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (ulpi_din),
        .stp      (ulpi_stp),
        .take     (phy_take),
        .nxt      (ulpi_nxt),
        .dir      (ulpi_dir),
        .rd_drive (rd_drive),
        .commit   (commit),
        .addr     (addr),
        .wdata    (wdata)
    );

    ulpi_reg_file #(
        .VENDOR_ID  (VENDOR_ID),
        .PRODUCT_ID (PRODUCT_ID),
        .CTRL_RST   (CTRL_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (commit),
        .addr       (addr),
        .wdata      (wdata),
        .stat_intr  (stat_intr),
        .stat_debug (stat_debug),
        .ctrl_q     (ctrl_q),
        .rd_data    (rd_data)
    );

    assign ulpi_dout     = rd_drive ? rd_data : '0;
    assign reg_func      = ctrl_q[0];
    assign reg_intf      = ctrl_q[1];
    assign reg_otg       = ctrl_q[2];
    assign reg_intr_rise = ctrl_q[3];
    assign reg_pwr       = ctrl_q[4];

endmodule

// File: rtl/ulpi_reg_engine_chk.sv
// Protocol checker for ulpi_reg_engine, attached by bind below.
// Observes only the top-level ports.
module ulpi_reg_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        stp,
    input logic        take,
    input logic        nxt,
    input logic        dir,
    input logic [7:0]  dout,
    input logic [39:0] regs
);

    // R4: NXT and DIR are never high together
    p_nxt_dir_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(nxt && dir));

    // R4: read data is zero unless the engine owns the bus
    p_dout_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dir |-> (dout == 8'h00));

    // R4: DIR lasts at most two cycles
    p_dir_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir && $past(dir)) |=> !dir);

    // R2: every NXT acknowledge is a single cycle
    p_nxt_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nxt |=> !nxt);

    // R2: register outputs change only after an STP cycle
    p_commit_on_stp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stp |=> $stable(regs));

    // R9: the PHY taking the bus leaves the engine idle
    p_take_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!nxt && !dir));

endmodule

bind ulpi_reg_engine ulpi_reg_engine_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .stp   (ulpi_stp),
    .take  (phy_take),
    .nxt   (ulpi_nxt),
    .dir   (ulpi_dir),
    .dout  (ulpi_dout),
    .regs  ({reg_pwr, reg_intr_rise, reg_otg, reg_intf, reg_func})
);

// File: tb/ulpi_reg_engine_tb.sv
// Self-checking bench: a behavioural model of the register contents and the
// expected bus signals for every cycle, compared on each clock.
module ulpi_reg_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic       stp = 1'b0;
    logic       take = 1'b0;
    logic [7:0] st_intr = 8'h00;
    logic [7:0] st_dbg = 8'h00;
    logic [7:0] dout;
    logic       dir;
    logic       nxt;
    logic [7:0] r_func, r_intf, r_otg, r_intr, r_pwr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] m_reg [5];
    int         m_base [5] = '{8'h04, 8'h07, 8'h0A, 8'h0D, 8'h3D};

    always #4 clk = ~clk;

    ulpi_reg_engine #(
        .VENDOR_ID  (16'hBEEF),
        .PRODUCT_ID (16'h0F5A),
        .FUNC_RST   (8'h41)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ulpi_din      (din),
        .ulpi_stp      (stp),
        .phy_take      (take),
        .stat_intr     (st_intr),
        .stat_debug    (st_dbg),
        .ulpi_dout     (dout),
        .ulpi_dir      (dir),
        .ulpi_nxt      (nxt),
        .reg_func      (r_func),
        .reg_intf      (r_intf),
        .reg_otg       (r_otg),
        .reg_intr_rise (r_intr),
        .reg_pwr       (r_pwr)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [7:0] a);
        for (int i = 0; i < 5; i++)
            if (a >= m_base[i] && a <= m_base[i] + 2) return m_reg[i];
        case (a)
            8'h00:   return 8'hEF;
            8'h01:   return 8'hBE;
            8'h02:   return 8'h5A;
            8'h03:   return 8'h0F;
            8'h13:   return st_intr;
            8'h15:   return st_dbg;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void m_write(input logic [7:0] a, input logic [7:0] d);
        for (int i = 0; i < 5; i++) begin
            if (a == m_base[i])          m_reg[i] = d;
            else if (a == m_base[i] + 1) m_reg[i] = m_reg[i] | d;
            else if (a == m_base[i] + 2) m_reg[i] = m_reg[i] & ~d;
        end
    endfunction

    // One clock: drive inputs after the falling edge, then compare all outputs.
    task automatic step(input logic [7:0] d, input logic s, input logic t,
                        input logic e_nxt, input logic e_dir,
                        input logic [7:0] e_dout, input string tag);
        logic [7:0] act [5];
        @(negedge clk);
        din = d; stp = s; take = t;
        #2;
        act = '{r_func, r_intf, r_otg, r_intr, r_pwr};
        check(nxt == e_nxt, tag, "nxt", nxt, e_nxt);
        check(dir == e_dir, tag, "dir", dir, e_dir);
        check(dout == e_dout, tag, "dout", dout, e_dout);
        for (int i = 0; i < 5; i++)
            check(act[i] == m_reg[i], tag, $sformatf("reg%0d", i), act[i], m_reg[i]);
    endtask

    task automatic send_cmd(input logic [7:0] cmd, input bit ext,
                            input logic [7:0] a, input string tag);
        step(cmd, 0, 0, 0, 0, 8'h00, tag);
        step(cmd, 0, 0, 1, 0, 8'h00, tag);
        if (ext) begin
            step(a, 0, 0, 0, 0, 8'h00, tag);
            step(a, 0, 0, 1, 0, 8'h00, tag);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input bit ext, input logic [7:0] d,
                            input int stall, input string tag);
        send_cmd(ext ? 8'hAF : {2'b10, a[5:0]}, ext, a, tag);
        step(d, 0, 0, 0, 0, 8'h00, tag);
        step(d, 0, 0, 1, 0, 8'h00, tag);
        for (int k = 0; k < stall; k++) step(8'h00, 0, 0, 0, 0, 8'h00, "R10");
        step(8'h00, 1, 0, 0, 0, 8'h00, tag);
        m_write(a, d);
    endtask

    task automatic do_read(input logic [7:0] a, input bit ext, input string tag);
        logic [7:0] e;
        send_cmd(ext ? 8'hEF : {2'b11, a[5:0]}, ext, a, tag);
        step(8'h00, 0, 0, 0, 1, 8'h00, tag);
        e = m_read(a);
        step(8'h00, 0, 0, 0, 1, e, tag);
        step(8'h00, 0, 0, 0, 0, 8'h00, tag);
    endtask

    initial begin
        m_reg = '{8'h41, 8'h00, 8'h00, 8'h00, 8'h00};
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state of the bus and the registers
        step(8'h00, 0, 0, 0, 0, 8'h00, "R1");
        // R2, R4: plain write and readback through every alias
        do_write(8'h04, 0, 8'h5A, 0, "R2");
        do_read(8'h04, 0, "R4");
        do_read(8'h05, 0, "R4");
        do_read(8'h06, 0, "R4");
        // R3: write, set, clear on all five control registers
        for (int i = 0; i < 5; i++) begin
            do_write(m_base[i][7:0], 0, 8'h3C ^ 8'(i), 0, "R3");
            do_write(m_base[i][7:0] + 8'd1, 0, 8'h81, 0, "R3");
            do_write(m_base[i][7:0] + 8'd2, 0, 8'h14, 0, "R3");
            do_read(m_base[i][7:0] + 8'd1, 0, "R3");
        end
        // R6: ID bytes, and a write to an ID address is ignored
        for (int a = 0; a < 4; a++) do_read(8'(a), 0, "R6");
        do_write(8'h01, 0, 8'h00, 0, "R6");
        do_read(8'h01, 0, "R6");
        // R5: extended addressing into control, ID and reserved space
        do_write(8'h3D, 1, 8'h77, 0, "R5");
        do_read(8'h3D, 1, "R5");
        do_write(8'h0B, 1, 8'h08, 0, "R5");
        do_read(8'h0A, 1, "R5");
        do_read(8'h02, 1, "R5");
        do_write(8'h80, 1, 8'hFF, 0, "R5");
        do_read(8'h80, 1, "R5");
        // R7: live status and debug values; writes there ignored
        st_intr = 8'hA5; st_dbg = 8'h03;
        do_read(8'h13, 0, "R7");
        do_read(8'h15, 0, "R7");
        do_write(8'h13, 0, 8'h00, 0, "R7");
        do_write(8'h15, 0, 8'hFF, 0, "R7");
        st_intr = 8'h5A;
        do_read(8'h13, 0, "R7");
        // R8: reserved addresses
        do_write(8'h20, 0, 8'hFF, 0, "R8");
        do_read(8'h20, 0, "R8");
        do_read(8'h2E, 0, "R8");
        do_read(8'h3C, 0, "R8");
        // R10: STP arrives after several idle cycles
        do_write(8'h07, 0, 8'hC3, 3, "R10");
        do_read(8'h07, 0, "R10");
        // R9: write dropped when take and STP coincide
        send_cmd(8'h84, 0, 8'h00, "R9");
        step(8'hFF, 0, 0, 0, 0, 8'h00, "R9");
        step(8'hFF, 0, 0, 1, 0, 8'h00, "R9");
        step(8'h00, 1, 1, 0, 0, 8'h00, "R9");
        step(8'h00, 0, 0, 0, 0, 8'h00, "R9");
        do_read(8'h04, 0, "R9");
        // R9: read cancelled during turnaround
        send_cmd(8'hC4, 0, 8'h00, "R9");
        step(8'h00, 0, 1, 0, 1, 8'h00, "R9");
        step(8'h00, 0, 0, 0, 0, 8'h00, "R9");
        // R9: command ignored while the PHY holds the bus
        step(8'h84, 0, 1, 0, 0, 8'h00, "R9");
        step(8'h00, 0, 0, 0, 0, 8'h00, "R9");
        step(8'h00, 0, 0, 0, 0, 8'h00, "R9");
        // R11: non-register bytes start nothing
        step(8'h41, 0, 0, 0, 0, 8'h00, "R11");
        step(8'h41, 0, 0, 0, 0, 8'h00, "R11");
        step(8'h3F, 0, 0, 0, 0, 8'h00, "R11");
        step(8'h00, 0, 0, 0, 0, 8'h00, "R11");
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule